// File: doc/BRIEF.md
# Vector Coprocessor Instruction Decoder

This block sits between a scalar integer core and an attached vector unit. It accepts one coprocessor-2 instruction at a time, along with the program counter of that instruction and the core's coprocessor-usable status bit. It classifies the instruction into one of four branches that test whether the vector unit is busy, one of four register transfers between the core and the vector unit, or an exception. For branches it produces the target address and the taken and delay-slot-nullify decisions. For transfers it produces the vector-unit register address, the destination register, and the completed transfer. A value read from the vector unit is sign-extended for the core's 64-bit register file.

The decoded instruction is held in a single issue register. Branch outcome, stall and transfer completion are evaluated from that register against the vector unit's status in the cycle after issue. A transfer may have to wait, depending on whether the vector unit is busy running a macro sequence or a micro program, and on the instruction's interlock bit. While it waits, the block holds `stall` high, keeps its outputs frozen, and refuses new issues.

Top module: `vcop_decoder`

## Requirements
- R1: After reset, `out_valid` and `stall` are 0 and `issue_ready` is 1.
- R2: An instruction issued with `cu2_usable` low raises only `exc_unusable`, whatever its encoding. No branch is taken, nothing is nullified, no reserved exception is raised and no transfer is performed.
- R3: Function field instr[25:21]=0x08 selects a branch, and instr[20:16] picks the form: 0 taken when idle, 1 taken when busy, 2 the likely form of 0, 3 the likely form of 1. The unit counts as busy when `vu_busy_macro` or `vu_busy_micro` is high.
- R4: For a branch, `target` = pc + 4 + (sign-extended instr[15:0] shifted left by 2), modulo 2^PC_W. `target` is 0 for anything else.
- R5: `nullify` is 1 only for a likely branch that is not taken. It is never 1 for an ordinary branch.
- R6: Transfers decode as follows. Function 0x02 is a 32-bit read from the unit and 0x06 is a 32-bit write to it; both require instr[10:1]=0. Function 0x01 is a quad read and 0x05 is a quad write. `reg_addr` = base + instr[15:11]×16, where the base is CTRL_BASE for the 32-bit forms and WIN_BASE for the quad forms. `out_rt` = instr[20:16]. Both outputs are 0 for non-transfers.
- R7: A 32-bit transfer with instr[10:1] nonzero, a branch with rt above 3, and any other function code each raise `exc_reserved` and have no other effect. The quad forms ignore instr[10:1].
- R8: While `vu_busy_macro` is high, a transfer stalls exactly while `vu_hazard_ids[instr[15:11]]` is set, and the interlock bit instr[0] has no effect. Branches never stall.
- R9: While only `vu_busy_micro` is high, a read transfer stalls while the unit stays busy, but only if instr[0]=1. A write transfer stalls until `vu_ilock_release` is 1, whatever instr[0] is.
- R10: In the cycle a read transfer completes, `gpr_we`=1 and `gpr_wdata` is `vu_rdata` sign-extended from bit 31 to 64 bits. In the cycle a write transfer completes, `vu_wr`=1. Otherwise these outputs are 0.
- R11: While `stall` is 1, `out_valid` stays 1, `issue_ready` is 0, and the decoded outputs hold their values.
- R12: An accepted issue produces `out_valid` in the next cycle, and the instruction completes in the first cycle after that in which no stall holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| issue_ready | output | 1 | Issue accepted this cycle (no stall) |
| instr | input | 32 | Coprocessor-2 instruction word |
| pc | input | PC_W | Address of the instruction |
| cu2_usable | input | 1 | Coprocessor-2 usable status bit |
| vu_busy_macro | input | 1 | Vector unit busy with a macro sequence |
| vu_busy_micro | input | 1 | Vector unit busy running a micro program |
| vu_hazard_ids | input | 32 | Per-register data hazard flags from the vector unit |
| vu_ilock_release | input | 1 | Vector unit releases a pending write interlock |
| vu_rdata | input | 32 | Data read from the addressed vector-unit register |
| out_valid | output | 1 | A decoded instruction is present |
| out_op | output | 4 | Decoded operation code |
| out_rt | output | 5 | Core register of a transfer |
| br_taken | output | 1 | Branch taken |
| nullify | output | 1 | Squash the delay-slot instruction |
| target | output | PC_W | Branch target |
| reg_addr | output | ADDR_W | Vector-unit register address |
| stall | output | 1 | Hold the core this cycle |
| exc_unusable | output | 1 | Coprocessor-unusable exception |
| exc_reserved | output | 1 | Reserved-instruction exception |
| gpr_we | output | 1 | Write core register with `gpr_wdata` |
| gpr_wdata | output | 64 | Sign-extended read data |
| vu_wr | output | 1 | Write transfer to the vector unit completes |

## Verification
Every result is due one cycle after the issuing edge, plus one extra cycle for each cycle in which a stall condition holds. The bench drives inputs on the falling edge and samples 1 ns later, so it reads the issue register together with the status it has just applied. For each instruction, the driver pushes the expected fields and the number of stall cycles it intends to apply. The monitor counts the cycles in which it sees `stall` with a valid output. On the first non-stalled valid sample, it pops the expected item and compares all fields and the stall count. A separate check confirms that `out_valid` rises exactly one sample after the issue.

// File: rtl/vcop_pkg.sv
package vcop_pkg;

    localparam int INSTR_W   = 32;
    localparam int ID_W      = 5;
    localparam int NUM_IDS   = 1 << ID_W;
    localparam int IMM_W     = 16;
    localparam int STRIDE_LG = 4;
    localparam int WORD_W    = 32;
    localparam int GPR_W     = 2 * WORD_W;

    localparam logic [4:0] FN_BRANCH  = 5'h08;
    localparam logic [4:0] FN_RD_CTL  = 5'h02;
    localparam logic [4:0] FN_RD_QUAD = 5'h01;
    localparam logic [4:0] FN_WR_CTL  = 5'h06;
    localparam logic [4:0] FN_WR_QUAD = 5'h05;

    typedef enum logic [3:0] {
        VOP_NONE    = 4'd0,
        VOP_BR_IDLE = 4'd1,
        VOP_BR_BUSY = 4'd2,
        VOP_BL_IDLE = 4'd3,
        VOP_BL_BUSY = 4'd4,
        VOP_RD_CTL  = 4'd5,
        VOP_RD_QUAD = 4'd6,
        VOP_WR_CTL  = 4'd7,
        VOP_WR_QUAD = 4'd8,
        VOP_EXC_CU  = 4'd9,
        VOP_EXC_RI  = 4'd10
    } vop_e;

    typedef struct packed {
        vop_e             op;
        logic [4:0]       rt;
        logic [ID_W-1:0]  id;
        logic [IMM_W-1:0] imm;
        logic             ilock;
    } vdec_t;

    function automatic logic op_is_branch(input vop_e op);
        return op inside {VOP_BR_IDLE, VOP_BR_BUSY, VOP_BL_IDLE, VOP_BL_BUSY};
    endfunction

    function automatic logic op_is_likely(input vop_e op);
        return op inside {VOP_BL_IDLE, VOP_BL_BUSY};
    endfunction

    function automatic logic op_wants_busy(input vop_e op);
        return op inside {VOP_BR_BUSY, VOP_BL_BUSY};
    endfunction

    function automatic logic op_is_read(input vop_e op);
        return op inside {VOP_RD_CTL, VOP_RD_QUAD};
    endfunction

    function automatic logic op_is_write(input vop_e op);
        return op inside {VOP_WR_CTL, VOP_WR_QUAD};
    endfunction

    function automatic logic op_is_quad(input vop_e op);
        return op inside {VOP_RD_QUAD, VOP_WR_QUAD};
    endfunction

endpackage

// File: rtl/vcop_classify.sv
module vcop_classify
    import vcop_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               cu2_usable,
    output vdec_t              dec
);
    logic [4:0] fn;
    logic       pad_zero;

    assign fn       = instr[25:21];
    assign pad_zero = (instr[10:1] == 10'd0);

    always_comb begin
        dec.rt    = instr[20:16];
        dec.id    = instr[15:11];
        dec.imm   = instr[15:0];
        dec.ilock = instr[0];
        dec.op    = VOP_EXC_RI;
        if (!cu2_usable) begin
            dec.op = VOP_EXC_CU;
        end else begin
            unique case (fn)
                FN_BRANCH: begin
                    unique case (instr[20:16])
                        5'd0:    dec.op = VOP_BR_IDLE;
                        5'd1:    dec.op = VOP_BR_BUSY;
                        5'd2:    dec.op = VOP_BL_IDLE;
                        5'd3:    dec.op = VOP_BL_BUSY;
                        default: dec.op = VOP_EXC_RI;
                    endcase
                end
                FN_RD_CTL:  dec.op = pad_zero ? VOP_RD_CTL : VOP_EXC_RI;
                FN_WR_CTL:  dec.op = pad_zero ? VOP_WR_CTL : VOP_EXC_RI;
                FN_RD_QUAD: dec.op = VOP_RD_QUAD;
                FN_WR_QUAD: dec.op = VOP_WR_QUAD;
                default:    dec.op = VOP_EXC_RI;
            endcase
        end
    end
endmodule

// File: rtl/vcop_issue_stage.sv
module vcop_issue_stage
    import vcop_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic            load_valid,
    input  vdec_t           load_dec,
    input  logic [PC_W-1:0] load_pc,
    output logic            valid_q,
    output vdec_t           dec_q,
    output logic [PC_W-1:0] pc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dec_q   <= '0;
            pc_q    <= '0;
        end else if (advance) begin
            valid_q <= load_valid;
            if (load_valid) begin
                dec_q <= load_dec;
                pc_q  <= load_pc;
            end
        end
    end
endmodule

// File: rtl/vcop_interlock.sv
module vcop_interlock
    import vcop_pkg::*;
(
    input  logic               valid,
    input  vdec_t              dec,
    input  logic               busy_macro,
    input  logic               busy_micro,
    input  logic [NUM_IDS-1:0] hazard_ids,
    input  logic               ilock_release,
    output logic               stall
);
    logic is_rd;
    logic is_wr;

    assign is_rd = op_is_read(dec.op);
    assign is_wr = op_is_write(dec.op);

    always_comb begin
        stall = 1'b0;
        if (valid && (is_rd || is_wr)) begin
            if (busy_macro) begin
                stall = hazard_ids[dec.id];
            end else if (busy_micro) begin
                stall = is_rd ? dec.ilock : !ilock_release;
            end
        end
    end
endmodule

// File: rtl/vcop_decoder.sv
module vcop_decoder
    import vcop_pkg::*;
#(
    parameter int              PC_W      = 32,
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 32'h0000_6000,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h0000_4000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_valid,
    output logic               issue_ready,
    input  logic [INSTR_W-1:0] instr,
    input  logic [PC_W-1:0]    pc,
    input  logic               cu2_usable,
    input  logic               vu_busy_macro,
    input  logic               vu_busy_micro,
    input  logic [NUM_IDS-1:0] vu_hazard_ids,
    input  logic               vu_ilock_release,
    input  logic [WORD_W-1:0]  vu_rdata,
    output logic               out_valid,
    output logic [3:0]         out_op,
    output logic [4:0]         out_rt,
    output logic               br_taken,
    output logic               nullify,
    output logic [PC_W-1:0]    target,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic               stall,
    output logic               exc_unusable,
    output logic               exc_reserved,
    output logic               gpr_we,
    output logic [GPR_W-1:0]   gpr_wdata,
    output logic               vu_wr
);
    localparam int BR_SHIFT = 2;
    localparam int EXT_W    = PC_W - IMM_W - BR_SHIFT;
    localparam logic [PC_W-1:0] INSTR_BYTES = PC_W'(4);

    vdec_t           dec_in;
    vdec_t           dec_q;
    logic            valid_q;
    logic [PC_W-1:0] pc_q;
    logic            advance;
    logic            busy_any;
    logic            is_br;
    logic            is_mv;
    logic            taken_raw;
    logic [PC_W-1:0] br_offset;

    vcop_classify u_classify (
        .instr      (instr),
        .cu2_usable (cu2_usable),
        .dec        (dec_in)
    );

    vcop_issue_stage #(.PC_W(PC_W)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .advance    (advance),
        .load_valid (issue_valid),
        .load_dec   (dec_in),
        .load_pc    (pc),
        .valid_q    (valid_q),
        .dec_q      (dec_q),
        .pc_q       (pc_q)
    );

    vcop_interlock u_interlock (
        .valid         (valid_q),
        .dec           (dec_q),
        .busy_macro    (vu_busy_macro),
        .busy_micro    (vu_busy_micro),
        .hazard_ids    (vu_hazard_ids),
        .ilock_release (vu_ilock_release),
        .stall         (stall)
    );

    assign advance     = !stall;
    assign issue_ready = !stall;
    assign busy_any    = vu_busy_macro || vu_busy_micro;
    assign is_br       = valid_q && op_is_branch(dec_q.op);
    assign is_mv       = valid_q && (op_is_read(dec_q.op) || op_is_write(dec_q.op));
    assign taken_raw   = op_wants_busy(dec_q.op) ? busy_any : !busy_any;
    assign br_offset   = {{EXT_W{dec_q.imm[IMM_W-1]}}, dec_q.imm, {BR_SHIFT{1'b0}}};

    always_comb begin
        out_valid    = valid_q;
        out_op       = valid_q ? dec_q.op : VOP_NONE;
        br_taken     = is_br && taken_raw;
        nullify      = is_br && op_is_likely(dec_q.op) && !taken_raw;
        target       = is_br ? (pc_q + INSTR_BYTES + br_offset) : '0;
        out_rt       = is_mv ? dec_q.rt : 5'd0;
        reg_addr     = '0;
        if (is_mv) begin
            reg_addr = (op_is_quad(dec_q.op) ? WIN_BASE : CTRL_BASE)
                     + (ADDR_W'(dec_q.id) << STRIDE_LG);
        end
        exc_unusable = valid_q && (dec_q.op == VOP_EXC_CU);
        exc_reserved = valid_q && (dec_q.op == VOP_EXC_RI);
        gpr_we       = valid_q && op_is_read(dec_q.op) && !stall;
        gpr_wdata    = gpr_we ? {{WORD_W{vu_rdata[WORD_W-1]}}, vu_rdata} : '0;
        vu_wr        = valid_q && op_is_write(dec_q.op) && !stall;
    end
endmodule

// File: rtl/vcop_decoder_chk.sv
module vcop_decoder_chk #(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_valid,
    input logic              issue_ready,
    input logic              out_valid,
    input logic              stall,
    input logic              br_taken,
    input logic              nullify,
    input logic              exc_unusable,
    input logic              exc_reserved,
    input logic              gpr_we,
    input logic [63:0]       gpr_wdata,
    input logic              vu_wr,
    input logic [PC_W-1:0]   target,
    input logic [ADDR_W-1:0] reg_addr
);
    assert_stall_valid_R11: assert property (@(posedge clk) disable iff (rst)
        stall |-> out_valid && !issue_ready);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && stall) |=> (out_valid && $stable(reg_addr) && $stable(target)));

    assert_issue_latency_R12: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_ready) |=> out_valid);

    assert_likely_only_untaken_R5: assert property (@(posedge clk) disable iff (rst)
        nullify |-> !br_taken);

    assert_unusable_alone_R2: assert property (@(posedge clk) disable iff (rst)
        exc_unusable |-> (!exc_reserved && !gpr_we && !vu_wr && !br_taken));

    assert_sign_extend_R10: assert property (@(posedge clk) disable iff (rst)
        gpr_we |-> (gpr_wdata[63:32] == {32{gpr_wdata[31]}}));

    assert_no_write_in_stall_R11: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!gpr_we && !vu_wr));
endmodule

bind vcop_decoder vcop_decoder_chk #(.PC_W(PC_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_vcop_decoder.sv
module test_vcop_decoder;
    localparam logic [31:0] CTRL_B = 32'h0000_6000;
    localparam logic [31:0] WIN_B  = 32'h0000_4000;

    typedef struct {
        logic        mac;
        logic        mic;
        logic [31:0] haz;
        logic        rel;
        logic [31:0] rdata;
    } st_t;

    typedef struct {
        string       tag;
        logic        unu;
        logic        ri;
        logic        tk;
        logic        nul;
        logic [31:0] tgt;
        logic [31:0] addr;
        logic [4:0]  rt;
        logic        gwe;
        logic [63:0] gwd;
        logic        vwr;
        int          stalls;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [31:0] instr = '0;
    logic [31:0] pc = '0;
    logic        cu2_usable = 1'b1;
    logic        vu_busy_macro = 1'b0;
    logic        vu_busy_micro = 1'b0;
    logic [31:0] vu_hazard_ids = '0;
    logic        vu_ilock_release = 1'b0;
    logic [31:0] vu_rdata = '0;
    logic        out_valid;
    logic [3:0]  out_op;
    logic [4:0]  out_rt;
    logic        br_taken;
    logic        nullify;
    logic [31:0] target;
    logic [31:0] reg_addr;
    logic        stall;
    logic        exc_unusable;
    logic        exc_reserved;
    logic        gpr_we;
    logic [63:0] gpr_wdata;
    logic        vu_wr;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    vcop_decoder i_vcop_decoder (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic st_t idle();
        st_t s;
        s.mac = 0; s.mic = 0; s.haz = '0; s.rel = 0; s.rdata = '0;
        return s;
    endfunction

    function automatic exp_t blank(input string tag);
        exp_t e;
        e.tag = tag; e.unu = 0; e.ri = 0; e.tk = 0; e.nul = 0; e.tgt = '0;
        e.addr = '0; e.rt = '0; e.gwe = 0; e.gwd = '0; e.vwr = 0; e.stalls = 0;
        return e;
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] fn, input logic [4:0] rt,
                                        input logic [15:0] low);
        return {6'b010010, fn, rt, low};
    endfunction

    task automatic apply(input st_t s);
        vu_busy_macro    = s.mac;
        vu_busy_micro    = s.mic;
        vu_hazard_ids    = s.haz;
        vu_ilock_release = s.rel;
        vu_rdata         = s.rdata;
    endtask

    task automatic send(input logic [31:0] ins, input logic [31:0] p, input logic cu,
                        input st_t hold, input int h, input st_t fin, input exp_t e);
        @(negedge clk);
        q.push_back(e);
        instr = ins; pc = p; cu2_usable = cu; issue_valid = 1'b1;
        for (int i = 0; i < h; i++) begin
            @(negedge clk);
            issue_valid = 1'b0;
            apply(hold);
            if (i == 0) begin
                #1;
                chk(out_valid === 1'b1, "R12", "valid one cycle after issue", out_valid, 1);
            end
        end
        @(negedge clk);
        issue_valid = 1'b0;
        apply(fin);
        if (h == 0) begin
            #1;
            chk(out_valid === 1'b1, "R12", "valid one cycle after issue", out_valid, 1);
        end
    endtask

    int          scnt = 0;
    logic [31:0] held_addr;
    bit          ready_seen;

    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            if (stall && !out_valid)
                chk(0, "R11", "stall without valid", stall, 0);
            if (out_valid && stall) begin
                if (scnt == 0) held_addr = reg_addr;
                else if (reg_addr !== held_addr)
                    chk(0, "R11", "addr held in stall", reg_addr, held_addr);
                if (issue_ready !== 1'b0) ready_seen = 1'b1;
                scnt++;
            end else if (out_valid) begin
                if (q.size() == 0) begin
                    chk(0, "R12", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(scnt == e.stalls, e.tag, "stall cycles", scnt, e.stalls);
                    chk({exc_unusable, exc_reserved} === {e.unu, e.ri}, e.tag, "exceptions",
                        {exc_unusable, exc_reserved}, {e.unu, e.ri});
                    chk({br_taken, nullify} === {e.tk, e.nul}, e.tag, "taken/nullify",
                        {br_taken, nullify}, {e.tk, e.nul});
                    chk(target === e.tgt, e.tag, "target", target, e.tgt);
                    chk({reg_addr, out_rt} === {e.addr, e.rt}, e.tag, "addr/rt",
                        {reg_addr, out_rt}, {e.addr, e.rt});
                    chk({gpr_we, vu_wr, gpr_wdata} === {e.gwe, e.vwr, e.gwd}, e.tag,
                        "transfer", gpr_wdata, e.gwd);
                    if (scnt > 0) begin
                        chk(reg_addr === held_addr, "R11", "addr stable to completion",
                            reg_addr, held_addr);
                        chk(!ready_seen, "R11", "issue_ready low in stall", ready_seen, 0);
                    end
                end
                scnt = 0;
                ready_seen = 1'b0;
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        st_t  s_idle, s_mac, s_mic, s_hold, s_fin;
        exp_t e;
        s_idle = idle();
        s_mac = idle(); s_mac.mac = 1;
        s_mic = idle(); s_mic.mic = 1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(out_valid === 1'b0, "R1", "out_valid", out_valid, 0);
        chk(stall === 1'b0, "R1", "stall", stall, 0);
        chk(issue_ready === 1'b1, "R1", "issue_ready", issue_ready, 1);

        // R2: unusable coprocessor, branch encoding, busy unit
        e = blank("R2"); e.unu = 1;
        send(mk(5'h08, 5'd1, 16'h0010), 32'h100, 1'b0, s_idle, 0, s_mac, e);
        // R2: unusable with a read encoding under micro busy
        e = blank("R2"); e.unu = 1;
        send(mk(5'h02, 5'd4, 16'h0001), 32'h100, 1'b0, s_idle, 0, s_mic, e);

        // R3 R4: branch-if-idle, unit idle -> taken
        e = blank("R3"); e.tk = 1; e.tgt = 32'h144;
        send(mk(5'h08, 5'd0, 16'h0010), 32'h100, 1'b1, s_idle, 0, s_idle, e);
        // R4 R5: branch-if-busy, idle, negative offset -> not taken, no nullify
        e = blank("R5"); e.tgt = 32'h0FC;
        send(mk(5'h08, 5'd1, 16'hFFFE), 32'h100, 1'b1, s_idle, 0, s_idle, e);
        // R5: likely idle-branch under macro busy -> not taken, nullify, wrap target
        e = blank("R5"); e.nul = 1; e.tgt = 32'hFFFE_2004;
        send(mk(5'h08, 5'd2, 16'h8000), 32'h2000, 1'b1, s_idle, 0, s_mac, e);
        // R3: likely busy-branch under micro busy -> taken
        e = blank("R3"); e.tk = 1; e.tgt = 32'h3000 + 4 + 32'h20;
        send(mk(5'h08, 5'd3, 16'h0008), 32'h3000, 1'b1, s_idle, 0, s_mic, e);
        // R8: branches never stall, even with hazards everywhere
        s_fin = s_mac; s_fin.haz = '1;
        e = blank("R8"); e.tk = 1; e.tgt = 32'h504;
        send(mk(5'h08, 5'd1, 16'h0000), 32'h500, 1'b1, s_idle, 0, s_fin, e);

        // R6 R10: 32-bit read, id 3, negative data
        s_fin = idle(); s_fin.rdata = 32'h8000_1234;
        e = blank("R10"); e.addr = CTRL_B + 32'h30; e.rt = 5'd9; e.gwe = 1;
        e.gwd = {{32{1'b1}}, 32'h8000_1234};
        send(mk(5'h02, 5'd9, {5'd3, 11'd0}), 32'h0, 1'b1, s_idle, 0, s_fin, e);
        // R6 R7 R10: quad read, id 31, pad field nonzero is ignored
        s_fin = idle(); s_fin.rdata = 32'h7FFF_0000;
        e = blank("R7"); e.addr = WIN_B + 32'h1F0; e.rt = 5'd2; e.gwe = 1;
        e.gwd = {32'h0, 32'h7FFF_0000};
        send(mk(5'h01, 5'd2, {5'd31, 11'h3FE}), 32'h0, 1'b1, s_idle, 0, s_fin, e);
        // R6 R10: 32-bit write id 5
        e = blank("R6"); e.addr = CTRL_B + 32'h50; e.rt = 5'd17; e.vwr = 1;
        send(mk(5'h06, 5'd17, {5'd5, 11'd0}), 32'h0, 1'b1, s_idle, 0, s_idle, e);
        // R6: quad write id 0
        e = blank("R6"); e.addr = WIN_B; e.rt = 5'd31; e.vwr = 1;
        send(mk(5'h05, 5'd31, 16'h0000), 32'h0, 1'b1, s_idle, 0, s_idle, e);

        // R7: reserved encodings
        e = blank("R7"); e.ri = 1;
        send(mk(5'h02, 5'd1, {5'd1, 11'h004}), 32'h0, 1'b1, s_idle, 0, s_idle, e);
        e = blank("R7"); e.ri = 1;
        send(mk(5'h06, 5'd1, {5'd1, 11'h400 >> 0}), 32'h0, 1'b1, s_idle, 0, s_idle, e);
        e = blank("R7"); e.ri = 1;
        send(mk(5'h03, 5'd1, 16'h0000), 32'h0, 1'b1, s_idle, 0, s_idle, e);
        e = blank("R7"); e.ri = 1;
        send(mk(5'h08, 5'd4, 16'h0010), 32'h40, 1'b1, s_idle, 0, s_mic, e);

        // R8: macro busy with hazard on id 7 for 3 cycles, then hazard elsewhere only
        s_hold = s_mac; s_hold.haz = 32'h0000_0080;
        s_fin = s_mac; s_fin.haz = 32'hFFFF_FF7F; s_fin.rdata = 32'h0000_0055;
        e = blank("R8"); e.addr = CTRL_B + 32'h70; e.rt = 5'd4; e.gwe = 1;
        e.gwd = 64'h55; e.stalls = 3;
        send(mk(5'h02, 5'd4, {5'd7, 11'd0}), 32'h0, 1'b1, s_hold, 3, s_fin, e);
        // R8: macro busy, no hazard, interlock bit set -> no stall
        e = blank("R8"); e.addr = CTRL_B + 32'h10; e.rt = 5'd6; e.gwe = 1; e.gwd = 64'h0;
        send(mk(5'h02, 5'd6, {5'd1, 11'd1}), 32'h0, 1'b1, s_idle, 0, s_mac, e);

        // R9: micro busy, read with interlock bit, 2 cycles, then idle
        s_fin = idle(); s_fin.rdata = 32'hFFFF_FFFE;
        e = blank("R9"); e.addr = WIN_B + 32'h20; e.rt = 5'd8; e.gwe = 1;
        e.gwd = 64'hFFFF_FFFF_FFFF_FFFE; e.stalls = 2;
        send(mk(5'h01, 5'd8, {5'd2, 11'd1}), 32'h0, 1'b1, s_mic, 2, s_fin, e);
        // R9: micro busy, read without interlock bit -> no stall
        e = blank("R9"); e.addr = CTRL_B + 32'h20; e.rt = 5'd8; e.gwe = 1; e.gwd = 64'h0;
        send(mk(5'h02, 5'd8, {5'd2, 11'd0}), 32'h0, 1'b1, s_idle, 0, s_mic, e);
        // R9: micro busy, write waits for release (4 cycles), bit0 clear
        s_fin = s_mic; s_fin.rel = 1;
        e = blank("R9"); e.addr = WIN_B + 32'hC0; e.rt = 5'd3; e.vwr = 1; e.stalls = 4;
        send(mk(5'h05, 5'd3, {5'd12, 11'd0}), 32'h0, 1'b1, s_mic, 4, s_fin, e);

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R12", "all results delivered", q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule